// File: doc/BRIEF.md
# USB PHY Bring-Up and Type-C Mux Sequencer

This block is a hardware state machine that takes a USB3 PHY from power-on to a working connection. After its own reset it holds the controller and PHY reset domains, releases the controller domain alone, and waits a settle interval before it reports ready. An init request then releases the PHY domain. The block polls an SRAM-ready flag in a status word at a fixed interval, with a bounded timeout. Once the flag is seen, it writes the load-done bit back into that word as a read-modify-write.

From then on, the block drives the Type-C orientation/mux control register through a simple write port (strobe, address, data). It also drives a VBUS enable request from the attach state, and it writes the mux register and changes VBUS only when that state actually changes. A strap input says whether an attach source exists. Without one, the block connects unflipped as soon as init completes. A shutdown request powers down, parks the mux in low-power mode and puts the PHY back into reset. Every timing figure is given in microseconds and converted through a clock-cycles-per-microsecond parameter. All inputs are synchronous to `clk`.

Top module: `phy_bringup_seq`

## Requirements
- R1: While `rst_n` is low, `ctl_rst` and `phy_rst` are high, and `ready`, `vbus_en`, `err`, `sram_ld_done` and `reg_we` are low. `ctl_rst` falls on the HOLD_US*CYC_PER_US-th rising edge after `rst_n` goes high, while `phy_rst` stays high.
- R2: `ready` rises exactly SETTLE_US*CYC_PER_US cycles after `ctl_rst` falls. `phy_rst` stays high until an init request is accepted. `ctl_rst` never stays high once `phy_rst` is low.
- R3: An `init_req` accepted while idle drops `phy_rst` in the next cycle. Bit SRAM_RDY_BIT (26) of `ctl_status` is sampled in the first polling cycle and then once every POLL_US*CYC_PER_US cycles.
- R4: If no sample sees the ready bit within TIMEOUT_US*CYC_PER_US cycles, `err` rises and no register write or VBUS change follows. `err` holds until the next `init_req`, which clears it and restarts polling.
- R5: A successful sample produces exactly one write to CTRL_ADDR. The data is the sampled status word with bit LD_DONE_BIT (25) set and all other bits unchanged. `sram_ld_done` rises in the same cycle and stays high until shutdown.
- R6: Mux word layout: bits [1:0] are the select (0 none, 1 USB, 2 DisplayPort, 3 both), bit 2 is flipped, bit 3 is low power, and bit 4 is valid. A connect writes 0x11, or 0x15 when flipped. A disconnect writes 0x18.
- R7: Once init is done, a mux write to MUX_ADDR is issued one cycle after the effective attach level differs from the recorded state. `vbus_en` follows the new state in the same cycle. A polarity change alone issues no write.
- R8: Changes on `attach` before init completes have no effect. The attach level present at completion is acted on right after the load-done write.
- R9: With `attach_src_present` low, the block writes 0x11 and raises `vbus_en` right after init, and then ignores `attach` and `polarity`.
- R10: A `shut_req` after init drops `vbus_en` and writes 0x18 in the next cycle. `phy_rst` rises one cycle later and `sram_ld_done` falls with it.
- R11: An `init_req` during polling or after init is ignored. A `shut_req` while idle, polling or in error is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | One-cycle init request |
| shut_req | input | 1 | One-cycle shutdown request |
| attach_src_present | input | 1 | Strap: an attach-detect source exists |
| attach | input | 1 | Cable attached level |
| polarity | input | 1 | 1 = reversed plug orientation |
| ctl_status | input | DW | Current PHY control/status word (ready flag at bit 26) |
| ctl_rst | output | 1 | Controller reset, active high |
| phy_rst | output | 1 | PHY reset, active high |
| ready | output | 1 | Controller released and settled |
| sram_ld_done | output | 1 | SRAM external load done |
| vbus_en | output | 1 | VBUS supply request |
| err | output | 1 | Sticky SRAM-ready timeout flag |
| reg_we | output | 1 | Register write strobe |
| reg_addr | output | AW | Register write address |
| reg_wdata | output | DW | Register write data |

## Verification
The bench raises the SRAM-ready flag between two samples and checks that it is seen only at the next sample point. A design that polls every cycle, or that polls on a drifting grid, completes early. It then lets one init run into the timeout and re-arms with a second init. A flag that is not sticky, or that is not cleared on re-init, shows up in `err`, and so does a design that writes the mux while in error.

Attach edges are applied before init, during steady connection, and as a polarity change alone. A design that acts on events instead of on a real difference in state either writes the mux before init or writes it twice. The no-source strap and an already-present cable are also covered; a design that skips the post-init sample never connects in those cases. Shutdown ordering is checked too: if the disconnect word comes after the PHY reset, or VBUS is left on, it shows up at the ports.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

   typedef enum logic [2:0] {
      ST_HOLD   = 3'd0,
      ST_SETTLE = 3'd1,
      ST_IDLE   = 3'd2,
      ST_POLL   = 3'd3,
      ST_LIVE   = 3'd4,
      ST_DRAIN  = 3'd5,
      ST_FAULT  = 3'd6
   } seq_state_e;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_USB  = 2'd1,
      SEL_DP   = 2'd2,
      SEL_BOTH = 2'd3
   } mux_sel_e;

   localparam int MUX_SEL_LSB   = 0;
   localparam int MUX_FLIP_BIT  = 2;
   localparam int MUX_LP_BIT    = 3;
   localparam int MUX_VALID_BIT = 4;

endpackage

// File: rtl/seq_cnt.sv
module seq_cnt #(
   parameter int W      = 8,
   parameter int PERIOD = 4,
   parameter bit WRAP   = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   output logic [W-1:0] cnt
);

   localparam logic [W-1:0] LAST = WRAP ? W'(PERIOD - 1) : {W{1'b1}};

   generate
      if (PERIOD < 1) begin : g_bad_period
         $error("seq_cnt: PERIOD must be at least 1");
      end
      if (WRAP && (PERIOD > (1 << W))) begin : g_bad_width
         $error("seq_cnt: W too narrow for PERIOD");
      end
   endgenerate

   logic [W-1:0] nxt;

   generate
      if (WRAP) begin : g_wrap
         always_comb nxt = (cnt == LAST) ? '0 : cnt + 1'b1;
      end else begin : g_sat
         always_comb nxt = (cnt == LAST) ? cnt : cnt + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (en)  cnt <= nxt;
   end

endmodule

// File: rtl/seq_mux_enc.sv
module seq_mux_enc
   import phy_seq_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          attached,
   input  logic          flipped,
   output logic [DW-1:0] word
);

   generate
      if (DW <= MUX_VALID_BIT) begin : g_bad_dw
         $error("seq_mux_enc: DW too narrow for the mux word");
      end
   endgenerate

   mux_sel_e sel;

   always_comb begin
      sel                       = attached ? SEL_USB : SEL_NONE;
      word                      = '0;
      word[MUX_SEL_LSB +: 2]    = sel;
      word[MUX_FLIP_BIT]        = attached & flipped;
      word[MUX_LP_BIT]          = ~attached;
      word[MUX_VALID_BIT]       = 1'b1;
   end

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
   import phy_seq_pkg::*;
#(
   parameter int            CYC_PER_US   = 50,
   parameter int            HOLD_US      = 1,
   parameter int            SETTLE_US    = 20,
   parameter int            POLL_US      = 10,
   parameter int            TIMEOUT_US   = 10000,
   parameter int            AW           = 16,
   parameter int            DW           = 32,
   parameter logic [AW-1:0] CTRL_ADDR    = AW'('h14),
   parameter logic [AW-1:0] MUX_ADDR     = AW'('h1014),
   parameter int            SRAM_RDY_BIT = 26,
   parameter int            LD_DONE_BIT  = 25
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init_req,
   input  logic          shut_req,
   input  logic          attach_src_present,
   input  logic          attach,
   input  logic          polarity,
   input  logic [DW-1:0] ctl_status,
   output logic          ctl_rst,
   output logic          phy_rst,
   output logic          ready,
   output logic          sram_ld_done,
   output logic          vbus_en,
   output logic          err,
   output logic          reg_we,
   output logic [AW-1:0] reg_addr,
   output logic [DW-1:0] reg_wdata
);

   localparam int HOLD_CYC   = HOLD_US * CYC_PER_US;
   localparam int SETTLE_CYC = SETTLE_US * CYC_PER_US;
   localparam int POLL_CYC   = POLL_US * CYC_PER_US;
   localparam int TMO_CYC    = TIMEOUT_US * CYC_PER_US;
   localparam int MAX_A      = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
   localparam int MAX_CYC    = (MAX_A > TMO_CYC) ? MAX_A : TMO_CYC;
   localparam int TW         = $clog2(MAX_CYC + 1);
   localparam int PW         = $clog2(POLL_CYC + 1);

   localparam logic [TW-1:0] HOLD_LAST   = TW'(HOLD_CYC - 1);
   localparam logic [TW-1:0] SETTLE_LAST = TW'(SETTLE_CYC - 1);
   localparam logic [TW-1:0] TMO_LAST    = TW'(TMO_CYC - 1);
   localparam logic [DW-1:0] LD_MASK     = DW'(1) << LD_DONE_BIT;

   generate
      if (CYC_PER_US < 1 || HOLD_US < 1 || SETTLE_US < 1 || POLL_US < 1) begin : g_bad_time
         $error("phy_bringup_seq: timing parameters must be at least 1");
      end
      if (TIMEOUT_US < POLL_US) begin : g_bad_tmo
         $error("phy_bringup_seq: timeout shorter than poll interval");
      end
      if (SRAM_RDY_BIT >= DW || LD_DONE_BIT >= DW || SRAM_RDY_BIT == LD_DONE_BIT) begin : g_bad_bits
         $error("phy_bringup_seq: status bit positions invalid");
      end
      if (CTRL_ADDR == MUX_ADDR) begin : g_bad_addr
         $error("phy_bringup_seq: register addresses must differ");
      end
   endgenerate

   seq_state_e st, st_n;

   logic [TW-1:0] ph_t;
   logic [PW-1:0] pl_t;
   logic          poll_hit;
   logic          eff_att, eff_flip;
   logic          linked;
   logic          relink;
   logic [DW-1:0] live_word, off_word;

   logic          we_q, vbus_q, ld_q, err_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;

   // phase timer: cleared on every state change, saturates
   seq_cnt #(.W(TW), .PERIOD(MAX_CYC), .WRAP(1'b0)) u_phase (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (st_n != st),
      .en   (1'b1),
      .cnt  (ph_t)
   );

   // poll grid: restarts on entry to polling, wraps every poll interval
   seq_cnt #(.W(PW), .PERIOD(POLL_CYC), .WRAP(1'b1)) u_poll (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (st != ST_POLL),
      .en   (1'b1),
      .cnt  (pl_t)
   );

   assign eff_att  = attach_src_present ? attach   : 1'b1;
   assign eff_flip = attach_src_present ? polarity : 1'b0;

   seq_mux_enc #(.DW(DW)) u_enc_live (
      .attached(eff_att),
      .flipped (eff_flip),
      .word    (live_word)
   );

   seq_mux_enc #(.DW(DW)) u_enc_off (
      .attached(1'b0),
      .flipped (1'b0),
      .word    (off_word)
   );

   assign poll_hit = (st == ST_POLL) && (pl_t == '0) && ctl_status[SRAM_RDY_BIT];
   assign relink   = (st == ST_LIVE) && !shut_req && (eff_att != linked);

   always_comb begin
      st_n = st;
      unique case (st)
         ST_HOLD:   if (ph_t == HOLD_LAST)   st_n = ST_SETTLE;
         ST_SETTLE: if (ph_t == SETTLE_LAST) st_n = ST_IDLE;
         ST_IDLE:   if (init_req)            st_n = ST_POLL;
         ST_POLL: begin
            if (poll_hit)                st_n = ST_LIVE;
            else if (ph_t == TMO_LAST)   st_n = ST_FAULT;
         end
         ST_LIVE:   if (shut_req)            st_n = ST_DRAIN;
         ST_DRAIN:                           st_n = ST_IDLE;
         ST_FAULT:  if (init_req)            st_n = ST_POLL;
         default:                            st_n = ST_HOLD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_HOLD;
         linked <= 1'b0;
         vbus_q <= 1'b0;
         ld_q   <= 1'b0;
         err_q  <= 1'b0;
         we_q   <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         st   <= st_n;
         we_q <= 1'b0;
         if (poll_hit) begin
            we_q   <= 1'b1;
            addr_q <= CTRL_ADDR;
            data_q <= ctl_status | LD_MASK;
            ld_q   <= 1'b1;
         end
         if (st == ST_POLL && st_n == ST_FAULT) err_q <= 1'b1;
         if (st == ST_FAULT && init_req)        err_q <= 1'b0;
         if (st == ST_LIVE && shut_req) begin
            we_q   <= 1'b1;
            addr_q <= MUX_ADDR;
            data_q <= off_word;
            vbus_q <= 1'b0;
            linked <= 1'b0;
         end else if (relink) begin
            we_q   <= 1'b1;
            addr_q <= MUX_ADDR;
            data_q <= live_word;
            vbus_q <= eff_att;
            linked <= eff_att;
         end
         if (st == ST_DRAIN) ld_q <= 1'b0;
      end
   end

   assign ctl_rst      = (st == ST_HOLD);
   assign phy_rst      = (st == ST_HOLD) || (st == ST_SETTLE) || (st == ST_IDLE);
   assign ready        = !((st == ST_HOLD) || (st == ST_SETTLE));
   assign sram_ld_done = ld_q;
   assign vbus_en      = vbus_q;
   assign err          = err_q;
   assign reg_we       = we_q;
   assign reg_addr     = addr_q;
   assign reg_wdata    = data_q;

endmodule

// File: rtl/phy_bringup_chk.sv
module phy_bringup_chk #(
   parameter int            AW          = 16,
   parameter int            DW          = 32,
   parameter logic [AW-1:0] CTRL_ADDR   = AW'('h14),
   parameter logic [AW-1:0] MUX_ADDR    = AW'('h1014),
   parameter int            LD_DONE_BIT = 25
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ctl_rst,
   input logic          phy_rst,
   input logic          ready,
   input logic          sram_ld_done,
   input logic          vbus_en,
   input logic          err,
   input logic          reg_we,
   input logic [AW-1:0] reg_addr,
   input logic [DW-1:0] reg_wdata
);

   localparam logic [DW-1:0] W_CONN  = DW'('h11);
   localparam logic [DW-1:0] W_FLIP  = DW'('h15);
   localparam logic [DW-1:0] W_DISC  = DW'('h18);

   p_ctl_under_phy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rst |-> phy_rst);

   p_ready_after_ctl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> !ctl_rst);

   p_write_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (reg_addr == CTRL_ADDR || reg_addr == MUX_ADDR));

   p_mux_word_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == MUX_ADDR) |->
         (reg_wdata == W_CONN || reg_wdata == W_FLIP || reg_wdata == W_DISC));

   p_vbus_with_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(vbus_en) |-> (reg_we && reg_addr == MUX_ADDR));

   p_err_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!reg_we && !vbus_en));

   p_ld_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_ld_done) |-> (reg_we && reg_addr == CTRL_ADDR && reg_wdata[LD_DONE_BIT]));

   p_reset_after_park_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phy_rst) |-> ($past(reg_we) && $past(reg_wdata) == W_DISC && !vbus_en));

endmodule

bind phy_bringup_seq phy_bringup_chk #(
   .AW         (AW),
   .DW         (DW),
   .CTRL_ADDR  (CTRL_ADDR),
   .MUX_ADDR   (MUX_ADDR),
   .LD_DONE_BIT(LD_DONE_BIT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctl_rst     (ctl_rst),
   .phy_rst     (phy_rst),
   .ready       (ready),
   .sram_ld_done(sram_ld_done),
   .vbus_en     (vbus_en),
   .err         (err),
   .reg_we      (reg_we),
   .reg_addr    (reg_addr),
   .reg_wdata   (reg_wdata)
);

// File: tb/sim_phy_bringup_seq.sv
`timescale 1ns/1ps
module sim_phy_bringup_seq;

   localparam int CPU = 4, HOLD = 1, SETTLE = 20, POLL = 10, TMO = 100;
   localparam int HOLD_C = HOLD * CPU, SETTLE_C = SETTLE * CPU;
   localparam int POLL_C = POLL * CPU, TMO_C = TMO * CPU;
   localparam logic [15:0] A_CTRL = 16'h0014, A_MUX = 16'h1014;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic init_req = 1'b0, shut_req = 1'b0;
   logic attach_src_present = 1'b1, attach = 1'b0, polarity = 1'b0;
   logic [31:0] ctl_status = '0;
   logic ctl_rst, phy_rst, ready, sram_ld_done, vbus_en, err, reg_we;
   logic [15:0] reg_addr;
   logic [31:0] reg_wdata;

   always #10 clk = ~clk;

   phy_bringup_seq #(
      .CYC_PER_US(CPU), .HOLD_US(HOLD), .SETTLE_US(SETTLE),
      .POLL_US(POLL), .TIMEOUT_US(TMO)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .init_req(init_req), .shut_req(shut_req),
      .attach_src_present(attach_src_present), .attach(attach), .polarity(polarity),
      .ctl_status(ctl_status), .ctl_rst(ctl_rst), .phy_rst(phy_rst), .ready(ready),
      .sram_ld_done(sram_ld_done), .vbus_en(vbus_en), .err(err), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata)
   );

   int checks = 0, fails = 0;
   bit done = 1'b0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   // phases: 0 hold, 1 settle, 2 idle, 3 polling, 4 running, 5 parking, 6 fault
   int m_ph, m_t;
   bit m_conn, m_vbus, m_ld, m_err, m_we;
   logic [15:0] m_addr;
   logic [31:0] m_data;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_t = 0; m_conn = 0; m_vbus = 0; m_ld = 0; m_err = 0; m_we = 0;
      end else begin
         bit ea, ef;
         m_we = 0;
         ea = attach_src_present ? attach : 1'b1;
         ef = attach_src_present ? polarity : 1'b0;
         case (m_ph)
            0: if (m_t == HOLD_C - 1) begin m_ph = 1; m_t = 0; end else m_t++;
            1: if (m_t == SETTLE_C - 1) begin m_ph = 2; m_t = 0; end else m_t++;
            2: if (init_req) begin m_ph = 3; m_t = 0; end
            3: begin
               if ((m_t % POLL_C) == 0 && ctl_status[26]) begin
                  m_we = 1; m_addr = A_CTRL; m_data = ctl_status | 32'h0200_0000;
                  m_ld = 1; m_ph = 4; m_t = 0;
               end else if (m_t == TMO_C - 1) begin
                  m_ph = 6; m_err = 1; m_t = 0;
               end else m_t++;
            end
            4: begin
               if (shut_req) begin
                  m_vbus = 0; m_conn = 0; m_we = 1; m_addr = A_MUX; m_data = 32'h18; m_ph = 5;
               end else if (ea != m_conn) begin
                  m_conn = ea; m_vbus = ea; m_we = 1; m_addr = A_MUX;
                  m_data = ea ? (32'h11 | (ef ? 32'h4 : 32'h0)) : 32'h18;
               end
            end
            5: begin m_ph = 2; m_ld = 0; end
            6: if (init_req) begin m_ph = 3; m_t = 0; m_err = 0; end
            default: m_ph = 0;
         endcase
      end
   end

   // per-cycle comparison and write log, away from the active edge
   logic [15:0] wq_a[$];
   logic [31:0] wq_d[$];

   always @(negedge clk) begin
      if (rst_n) begin
         check("R1 ctl_rst", {31'b0, ctl_rst}, {31'b0, m_ph == 0});
         check("R2 phy_rst", {31'b0, phy_rst}, {31'b0, m_ph <= 2});
         check("R2 ready", {31'b0, ready}, {31'b0, m_ph >= 2});
         check("R7 vbus_en", {31'b0, vbus_en}, {31'b0, m_vbus});
         check("R4 err", {31'b0, err}, {31'b0, m_err});
         check("R5 sram_ld_done", {31'b0, sram_ld_done}, {31'b0, m_ld});
         check("R7 reg_we", {31'b0, reg_we}, {31'b0, m_we});
         if (m_we) begin
            check("R6 reg_addr", {16'b0, reg_addr}, {16'b0, m_addr});
            check("R6 reg_wdata", reg_wdata, m_data);
         end
         if (reg_we) begin wq_a.push_back(reg_addr); wq_d.push_back(reg_wdata); end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_init();
      @(negedge clk) init_req = 1'b1;
      @(negedge clk) init_req = 1'b0;
   endtask

   task automatic pulse_shut();
      @(negedge clk) shut_req = 1'b1;
      @(negedge clk) shut_req = 1'b0;
   endtask

   task automatic clear_log();
      wq_a.delete(); wq_d.delete();
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      tick(3);
      check("R1 reset ctl_rst", {31'b0, ctl_rst}, 32'd1);
      check("R1 reset phy_rst", {31'b0, phy_rst}, 32'd1);
      check("R1 reset quiet", {28'b0, ready, vbus_en, err, reg_we}, 32'd0);
      rst_n = 1'b1;
   endtask

   initial begin
      int n;
      do_reset();
      // R1: hold length, R2: settle length
      n = 1;
      forever begin @(negedge clk); if (ctl_rst) n++; else break; end
      check("R1 hold cycles", n, HOLD_C);
      check("R1 phy_rst held", {31'b0, phy_rst}, 32'd1);
      n = 1;
      forever begin @(negedge clk); if (!ready) n++; else break; end
      check("R2 settle cycles", n, SETTLE_C);

      // R8: attach activity before init; R11: shutdown while idle
      clear_log();
      attach = 1'b1; polarity = 1'b1; tick(10); attach = 1'b0; tick(5);
      pulse_shut(); tick(5);
      check("R8 no write before init", wq_a.size(), 0);
      check("R11 idle shut ignored", {30'b0, phy_rst, vbus_en}, 32'd2);

      // R4: timeout
      ctl_status = 32'h0000_00A5;
      pulse_init(); tick(1);
      check("R3 phy_rst released", {31'b0, phy_rst}, 32'd0);
      pulse_shut();
      tick(TMO_C + 5);
      check("R4 err sticky", {31'b0, err}, 32'd1);
      check("R4 no write in error", wq_a.size(), 0);
      tick(20);
      check("R4 err holds", {31'b0, err}, 32'd1);

      // R5/R8: re-init with cable present, flag set between samples
      attach = 1'b1; polarity = 1'b1;
      pulse_init(); tick(1);
      check("R4 err cleared", {31'b0, err}, 32'd0);
      pulse_init(); // R11: ignored during polling
      tick(POLL_C + 10);
      ctl_status = 32'h0400_00A5;
      tick(POLL_C + 5);
      check("R5 write count", wq_a.size(), 2);
      if (wq_a.size() == 2) begin
         check("R5 ctrl addr", {16'b0, wq_a[0]}, {16'b0, A_CTRL});
         check("R5 rmw data", wq_d[0], 32'h0600_00A5);
         check("R8 mux addr", {16'b0, wq_a[1]}, {16'b0, A_MUX});
         check("R6 flipped connect", wq_d[1], 32'h15);
      end
      check("R7 vbus on", {31'b0, vbus_en}, 32'd1);
      check("R5 ld level", {31'b0, sram_ld_done}, 32'd1);

      // R11 init while running; R7 polarity only; detach; reattach
      clear_log();
      pulse_init(); tick(5);
      polarity = 1'b0; tick(5);
      check("R7 polarity alone", wq_a.size(), 0);
      attach = 1'b0; tick(4);
      check("R7 detach write", wq_a.size(), 1);
      if (wq_a.size() == 1) check("R6 disconnect word", wq_d[0], 32'h18);
      check("R7 vbus off", {31'b0, vbus_en}, 32'd0);
      tick(6);
      check("R7 no repeat", wq_a.size(), 1);
      attach = 1'b1; tick(4);
      if (wq_a.size() == 2) check("R6 plain connect", wq_d[1], 32'h11);
      else check("R7 reattach count", wq_a.size(), 2);

      // R10 shutdown
      clear_log();
      pulse_shut(); tick(3);
      check("R10 park write", wq_a.size(), 1);
      if (wq_a.size() == 1) check("R10 park word", wq_d[0], 32'h18);
      check("R10 phy_rst back", {31'b0, phy_rst}, 32'd1);
      check("R10 vbus/ld off", {30'b0, vbus_en, sram_ld_done}, 32'd0);
      pulse_shut(); tick(3);
      check("R11 second shut ignored", wq_a.size(), 1);

      // R9: no attach source
      attach_src_present = 1'b0; attach = 1'b0; polarity = 1'b1;
      ctl_status = 32'h0400_0000;
      do_reset();
      tick(HOLD_C + SETTLE_C + 5);
      clear_log();
      pulse_init(); tick(5);
      check("R9 write count", wq_a.size(), 2);
      if (wq_a.size() == 2) check("R9 strap connect", wq_d[1], 32'h11);
      check("R9 vbus on", {31'b0, vbus_en}, 32'd1);
      attach = 1'b1; tick(3); attach = 1'b0; polarity = 1'b0; tick(5);
      check("R9 inputs ignored", wq_a.size(), 2);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule